// File: doc/BRIEF.md
# E-Paper Controller Power-Up Sequencer

This block runs once after system reset and brings an e-paper timing controller into a usable state. It holds chip select inactive and pulses the panel reset for a fixed number of millisecond ticks. It then moves through a fixed list of framed word transfers on an external SPI word engine. Before each word it waits for the controller's host-ready line. The list reads the controller's device-information block, switches the controller into packed host mode and reads the VCOM setting. It writes the VCOM setting only when the value read back differs from the configured one.

After the VCOM step the sequencer raises the fast-clock select for the SPI engine. It then issues a full-panel display-area command in mode 0 and raises `ready`. The captured device-information words stay readable through a registered read port. The image buffer address held in them is also presented as a 32-bit output.

Each transaction is a frame: chip select goes low, a preamble word is sent, then the payload words follow, and chip select returns high. A command frame sends preamble 0x6000 and then the opcode. A write frame sends preamble 0x0000 and then one data word. A read frame sends preamble 0x1000, then one dummy word 0x0000, then one 0x0000 fill word for each word returned.

Top module: `epd_bringup_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `panel_rst_n` and `cs_n` are 1, and `xfer_valid`, `spi_fast` and `ready` are 0.
- R2: After reset, `panel_rst_n` is driven low for exactly RESET_MS cycles in which `ms_tick` is high, and then released. `cs_n` stays high and no transfer is requested while `panel_rst_n` is low. All transfers happen after the release.
- R3: Every frame is one separate low period of `cs_n`. A command frame is 0x6000 followed by the opcode. A write frame is 0x0000 followed by the data word. A read frame of N words is 0x1000, then 0x0000, then N words of 0x0000. The data returned with the last N words is captured in order.
- R4: A word request starts only after `host_rdy` was sampled high. Exactly one request is outstanding at a time, and it is held with a stable word until `xfer_done`.
- R5: The first frames are command 0x0302 and then a read of INFO_WORDS words. Word k of that read is returned on `info_data` one cycle after `info_addr` = k.
- R6: `img_addr` holds device-info word 3 in bits 31:16 and word 2 in bits 15:0.
- R7: Packed host mode is set with command 0x0011, then a write of 0x0004, then a write of 0x0001.
- R8: VCOM is then read with command 0x0039, a write of 0x0000, and a one-word read.
- R9: Only when the word read differs from VCOM_MV do the next frames follow: command 0x0039, a write of 0x0001, and a write of VCOM_MV. Otherwise these frames are omitted.
- R10: `spi_fast` is 0 for every transfer up to and including the VCOM step. It rises while `cs_n` is high, before the display-area command, and it then stays 1.
- R11: The last frames are command 0x0034, followed by writes of 0, 0, PANEL_W, PANEL_H and 0 (x, y, width, height, mode).
- R12: `ready` rises after the last frame has ended and stays 1, and no further transfer is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| host_rdy | input | 1 | Controller ready for the next word |
| xfer_done | input | 1 | SPI engine finished the current word |
| xfer_rdata | input | 16 | Word received in the finished transfer |
| info_addr | input | INFO_AW | Device-info word index to read |
| panel_rst_n | output | 1 | Active-low panel reset |
| cs_n | output | 1 | Active-low chip select |
| spi_fast | output | 1 | Selects the fast SPI clock |
| xfer_valid | output | 1 | Word transfer request |
| xfer_wdata | output | 16 | Word to transmit |
| info_data | output | 16 | Registered device-info word |
| img_addr | output | 32 | Image buffer address from the device info |
| ready | output | 1 | Initialization complete |

## Verification
The bench sets RESET_MS to 3 and pulses `ms_tick` every eight clocks. This keeps the reset pulse short enough that the full frame list can be run several times, and the tick count during reset can be compared exactly. INFO_WORDS, the panel size and VCOM_MV keep their defaults. The whole 20-word device-info block, the address words in it, and the 1872 and 1404 extent words are therefore checked at their real values. The returned VCOM is set equal to VCOM_MV in one run and different from it in two others, so that both branches of the conditional write are covered. One of those runs holds `host_rdy` low for part of every seven cycles and lengthens the engine latency, which exercises the ready wait.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  typedef enum logic [1:0] {
    FK_CMD = 2'd0,
    FK_WR  = 2'd1,
    FK_RD  = 2'd2
  } frame_kind_e;

  localparam logic [15:0] PRE_CMD = 16'h6000;
  localparam logic [15:0] PRE_WR  = 16'h0000;
  localparam logic [15:0] PRE_RD  = 16'h1000;
  localparam logic [15:0] FILL_W  = 16'h0000;

  localparam logic [15:0] OP_DEVINFO = 16'h0302;
  localparam logic [15:0] OP_REGWR   = 16'h0011;
  localparam logic [15:0] OP_VCOM    = 16'h0039;
  localparam logic [15:0] OP_AREA    = 16'h0034;
  localparam logic [15:0] REG_HOSTMODE    = 16'h0004;
  localparam logic [15:0] HOSTMODE_PACKED = 16'h0001;

  localparam int STEP_W = 5;
  localparam logic [STEP_W-1:0] SP_INFO_CMD  = 5'd0;
  localparam logic [STEP_W-1:0] SP_INFO_RD   = 5'd1;
  localparam logic [STEP_W-1:0] SP_VCOM_RD   = 5'd7;
  localparam logic [STEP_W-1:0] SP_VCOM_WCMD = 5'd8;
  localparam logic [STEP_W-1:0] SP_AREA_CMD  = 5'd11;
  localparam logic [STEP_W-1:0] SP_LAST      = 5'd16;

  // Word transmitted at position idx of a frame.
  function automatic logic [15:0] frame_word(frame_kind_e k, logic [7:0] idx,
                                             logic [15:0] arg);
    logic [15:0] w;
    case (k)
      FK_CMD:  w = (idx == 8'd0) ? PRE_CMD : arg;
      FK_WR:   w = (idx == 8'd0) ? PRE_WR  : arg;
      default: w = (idx == 8'd0) ? PRE_RD  : FILL_W;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/epd_reset_timer.sv
module epd_reset_timer #(
  parameter int RESET_MS = 100,
  localparam int CW = $clog2(RESET_MS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ms_tick,
  output logic panel_rst_n,
  output logic done
);
  localparam logic [CW-1:0] LIM = CW'(RESET_MS - 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      panel_rst_n <= 1'b1;
      cnt         <= '0;
      run         <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run         <= 1'b1;
        panel_rst_n <= 1'b0;
        cnt         <= '0;
      end else if (run && ms_tick) begin
        if (cnt == LIM) begin
          run         <= 1'b0;
          panel_rst_n <= 1'b1;
          done        <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/epd_frame_engine.sv
module epd_frame_engine
  import epd_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  frame_kind_e      kind,
  input  logic [15:0]      arg,
  input  logic [CNT_W-1:0] rd_words,
  input  logic             host_rdy,
  input  logic             xfer_done,
  input  logic [15:0]      xfer_rdata,
  output logic             cs_n,
  output logic             xfer_valid,
  output logic [15:0]      xfer_wdata,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_idx,
  output logic [15:0]      rd_data,
  output logic             done
);
  typedef enum logic [1:0] {E_IDLE, E_WAIT, E_XFER, E_END} eng_st_e;

  eng_st_e          st;
  frame_kind_e      kind_q;
  logic [15:0]      arg_q;
  logic [CNT_W-1:0] idx, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= E_IDLE;
      kind_q     <= FK_CMD;
      arg_q      <= '0;
      idx        <= '0;
      last_q     <= '0;
      cs_n       <= 1'b1;
      xfer_valid <= 1'b0;
      xfer_wdata <= '0;
      rd_valid   <= 1'b0;
      rd_idx     <= '0;
      rd_data    <= '0;
      done       <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          kind_q <= kind;
          arg_q  <= arg;
          last_q <= (kind == FK_RD) ? rd_words + CNT_W'(1) : CNT_W'(1);
          idx    <= '0;
          cs_n   <= 1'b0;
          st     <= E_WAIT;
        end
        E_WAIT: if (host_rdy) begin
          xfer_valid <= 1'b1;
          xfer_wdata <= frame_word(kind_q, 8'(idx), arg_q);
          st         <= E_XFER;
        end
        E_XFER: if (xfer_done) begin
          xfer_valid <= 1'b0;
          if (kind_q == FK_RD && idx >= CNT_W'(2)) begin
            rd_valid <= 1'b1;
            rd_idx   <= idx - CNT_W'(2);
            rd_data  <= xfer_rdata;
          end
          if (idx == last_q) begin
            st <= E_END;
          end else begin
            idx <= idx + 1'b1;
            st  <= E_WAIT;
          end
        end
        default: begin
          cs_n <= 1'b1;
          done <= 1'b1;
          st   <= E_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/epd_info_store.sv
module epd_info_store #(
  parameter int DEPTH = 20,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/epd_bringup_seq.sv
module epd_bringup_seq
  import epd_seq_pkg::*;
#(
  parameter int          RESET_MS   = 100,
  parameter int          INFO_WORDS = 20,
  parameter logic [15:0] PANEL_W    = 16'd1872,
  parameter logic [15:0] PANEL_H    = 16'd1404,
  parameter logic [15:0] VCOM_MV    = 16'd1500,
  localparam int         INFO_AW    = $clog2(INFO_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ms_tick,
  input  logic               host_rdy,
  input  logic               xfer_done,
  input  logic [15:0]        xfer_rdata,
  input  logic [INFO_AW-1:0] info_addr,
  output logic               panel_rst_n,
  output logic               cs_n,
  output logic               spi_fast,
  output logic               xfer_valid,
  output logic [15:0]        xfer_wdata,
  output logic [15:0]        info_data,
  output logic [31:0]        img_addr,
  output logic               ready
);
  localparam int CNT_W = $clog2(INFO_WORDS + 2);

  typedef enum logic [2:0] {S_BOOT, S_RST, S_ISSUE, S_WAIT, S_DONE} seq_st_e;

  seq_st_e           st;
  logic [STEP_W-1:0] step;
  logic              tmr_start, tmr_done;
  logic              eng_start, eng_done;
  frame_kind_e       cur_kind;
  logic [15:0]       cur_arg;
  logic [CNT_W-1:0]  cur_rdn;
  logic              rd_valid;
  logic [CNT_W-1:0]  rd_idx;
  logic [15:0]       rd_data;
  logic [15:0]       vcom_rd;
  logic              info_we;

  // Step list: opcode frames with their argument words.
  always_comb begin
    cur_kind = FK_WR;
    cur_arg  = 16'h0000;
    cur_rdn  = CNT_W'(1);
    case (step)
      5'd0:  begin cur_kind = FK_CMD; cur_arg = OP_DEVINFO; end
      5'd1:  begin cur_kind = FK_RD;  cur_rdn = CNT_W'(INFO_WORDS); end
      5'd2:  begin cur_kind = FK_CMD; cur_arg = OP_REGWR; end
      5'd3:  cur_arg = REG_HOSTMODE;
      5'd4:  cur_arg = HOSTMODE_PACKED;
      5'd5:  begin cur_kind = FK_CMD; cur_arg = OP_VCOM; end
      5'd6:  cur_arg = 16'h0000;
      5'd7:  cur_kind = FK_RD;
      5'd8:  begin cur_kind = FK_CMD; cur_arg = OP_VCOM; end
      5'd9:  cur_arg = 16'h0001;
      5'd10: cur_arg = VCOM_MV;
      5'd11: begin cur_kind = FK_CMD; cur_arg = OP_AREA; end
      5'd14: cur_arg = PANEL_W;
      5'd15: cur_arg = PANEL_H;
      default: cur_arg = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_BOOT;
      step      <= '0;
      tmr_start <= 1'b0;
      eng_start <= 1'b0;
      spi_fast  <= 1'b0;
      ready     <= 1'b0;
    end else begin
      tmr_start <= 1'b0;
      eng_start <= 1'b0;
      case (st)
        S_BOOT: begin
          tmr_start <= 1'b1;
          st        <= S_RST;
        end
        S_RST: if (tmr_done) st <= S_ISSUE;
        S_ISSUE: begin
          if (step == SP_VCOM_WCMD && vcom_rd == VCOM_MV) begin
            step <= SP_AREA_CMD;
          end else if (step == SP_AREA_CMD && !spi_fast) begin
            spi_fast <= 1'b1;
          end else begin
            eng_start <= 1'b1;
            st        <= S_WAIT;
          end
        end
        S_WAIT: if (eng_done) begin
          if (step == SP_LAST) begin
            ready <= 1'b1;
            st    <= S_DONE;
          end else begin
            step <= step + 1'b1;
            st   <= S_ISSUE;
          end
        end
        default: ready <= 1'b1;
      endcase
    end
  end

  // Captured read data: device info words and the VCOM readback.
  assign info_we = rd_valid && (step == SP_INFO_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      img_addr <= '0;
      vcom_rd  <= '0;
    end else if (rd_valid) begin
      if (step == SP_INFO_RD && rd_idx == CNT_W'(2)) img_addr[15:0]  <= rd_data;
      if (step == SP_INFO_RD && rd_idx == CNT_W'(3)) img_addr[31:16] <= rd_data;
      if (step == SP_VCOM_RD) vcom_rd <= rd_data;
    end
  end

  epd_reset_timer #(.RESET_MS(RESET_MS)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .start      (tmr_start),
    .ms_tick    (ms_tick),
    .panel_rst_n(panel_rst_n),
    .done       (tmr_done)
  );

  epd_frame_engine #(.CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (eng_start),
    .kind      (cur_kind),
    .arg       (cur_arg),
    .rd_words  (cur_rdn),
    .host_rdy  (host_rdy),
    .xfer_done (xfer_done),
    .xfer_rdata(xfer_rdata),
    .cs_n      (cs_n),
    .xfer_valid(xfer_valid),
    .xfer_wdata(xfer_wdata),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .done      (eng_done)
  );

  epd_info_store #(.DEPTH(INFO_WORDS), .DW(16)) u_info (
    .clk  (clk),
    .we   (info_we),
    .waddr(rd_idx[INFO_AW-1:0]),
    .wdata(rd_data),
    .raddr(info_addr),
    .rdata(info_data)
  );
endmodule

// File: rtl/epd_bringup_seq_chk.sv
module epd_bringup_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_rdy,
  input logic        xfer_done,
  input logic        panel_rst_n,
  input logic        cs_n,
  input logic        spi_fast,
  input logic        xfer_valid,
  input logic [15:0] xfer_wdata,
  input logic        ready
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (cs_n && panel_rst_n && !xfer_valid && !spi_fast && !ready)); // R1

  AST_CS_HIGH_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !panel_rst_n |-> cs_n); // R2

  AST_NO_XFER_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !panel_rst_n |-> !xfer_valid); // R2

  AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> !cs_n); // R3

  AST_START_ON_RDY: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_valid) |-> $past(host_rdy)); // R4

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(xfer_wdata))); // R4

  AST_FAST_STICKY: assert property (@(posedge clk) disable iff (rst)
    spi_fast |=> spi_fast); // R10

  AST_FAST_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_fast) |-> cs_n); // R10

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    ready |=> (ready && !xfer_valid)); // R12
endmodule

bind epd_bringup_seq epd_bringup_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_rdy   (host_rdy),
  .xfer_done  (xfer_done),
  .panel_rst_n(panel_rst_n),
  .cs_n       (cs_n),
  .spi_fast   (spi_fast),
  .xfer_valid (xfer_valid),
  .xfer_wdata (xfer_wdata),
  .ready      (ready)
);

// File: tb/tb_epd_bringup_seq.sv
module tb_epd_bringup_seq;
  localparam int RST_MS = 3;
  localparam int NW     = 20;
  localparam int TICK_DIV = 8;
  localparam logic [15:0] VCOM_CFG = 16'd1500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic        host_rdy = 1'b1;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_rdata = '0;
  logic [4:0]  info_addr = '0;
  logic        panel_rst_n, cs_n, spi_fast, xfer_valid, ready;
  logic [15:0] xfer_wdata, info_data;
  logic [31:0] img_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  epd_bringup_seq #(.RESET_MS(RST_MS)) dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .host_rdy(host_rdy),
    .xfer_done(xfer_done), .xfer_rdata(xfer_rdata), .info_addr(info_addr),
    .panel_rst_n(panel_rst_n), .cs_n(cs_n), .spi_fast(spi_fast),
    .xfer_valid(xfer_valid), .xfer_wdata(xfer_wdata), .info_data(info_data),
    .img_addr(img_addr), .ready(ready)
  );

  function automatic logic [15:0] pat(int k);
    return 16'hC300 ^ (16'(k) * 16'h0111);
  endfunction

  // Device and SPI engine model state
  logic [15:0] vcom_model = 16'd1500;
  bit          busy_mode = 0;
  int          lat_cfg = 2;
  int cyc, tdiv, lat, widx, frame, lowticks, csbad, rdybad, prstbad;
  bit pending, cs_prev, xv_prev;
  logic [15:0] fr_first, last_cmd;
  int          log_n;
  logic [15:0] log_w [128];
  int          log_f [128];
  bit          log_fast [128];

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; tdiv = 0; lat = 0; widx = 0; frame = -1; lowticks = 0;
      csbad = 0; rdybad = 0; prstbad = 0; pending = 0; cs_prev = 1;
      xv_prev = 0; fr_first = '0; last_cmd = '0; log_n = 0;
      xfer_done = 0; ms_tick = 0; host_rdy = 1;
    end else begin
      cyc++;
      if (xfer_valid && !xv_prev && !host_rdy) rdybad++;
      xv_prev = xfer_valid;
      host_rdy = busy_mode ? ((cyc % 7) < 4) : 1'b1;
      tdiv = (tdiv + 1) % TICK_DIV;
      ms_tick = (tdiv == 0);
      if (ms_tick && !panel_rst_n) lowticks++;
      if (!panel_rst_n && !cs_n) csbad++;
      if (!cs_n && cs_prev) begin frame++; widx = 0; end
      cs_prev = cs_n;
      if (xfer_done) xfer_done = 0;
      else if (xfer_valid && !pending) begin pending = 1; lat = lat_cfg; end
      else if (pending) begin
        if (lat == 0) begin
          xfer_rdata = 16'h0000;
          if (fr_first == 16'h1000 && widx >= 2)
            xfer_rdata = (last_cmd == 16'h0302) ? pat(widx - 2) : vcom_model;
          xfer_done = 1;
          pending = 0;
          if (!panel_rst_n) prstbad++;
          if (log_n < 128) begin
            log_w[log_n] = xfer_wdata; log_f[log_n] = frame;
            log_fast[log_n] = spi_fast; log_n++;
          end
          if (widx == 0) fr_first = xfer_wdata;
          if (widx == 1 && fr_first == 16'h6000) last_cmd = xfer_wdata;
          widx++;
        end else lat--;
      end
    end
  end

  // Expected transfer list
  int          ex_n, ex_frame;
  bit          ex_fast;
  logic [15:0] ex_w [128];
  int          ex_f [128];
  bit          ex_fs [128];
  string       ex_tag [128];

  task automatic push(logic [15:0] w, string tag);
    ex_w[ex_n] = w; ex_f[ex_n] = ex_frame; ex_fs[ex_n] = ex_fast;
    ex_tag[ex_n] = tag; ex_n++;
  endtask
  task automatic ex_cmd(logic [15:0] c, string tag);
    push(16'h6000, tag); push(c, tag); ex_frame++;
  endtask
  task automatic ex_wr(logic [15:0] w, string tag);
    push(16'h0000, tag); push(w, tag); ex_frame++;
  endtask
  task automatic ex_rd(int n, string tag);
    push(16'h1000, tag); push(16'h0000, tag);
    for (int i = 0; i < n; i++) push(16'h0000, tag);
    ex_frame++;
  endtask

  task automatic build_expected(bit differs);
    ex_n = 0; ex_frame = 0; ex_fast = 0;
    ex_cmd(16'h0302, "R5"); ex_rd(NW, "R5");
    ex_cmd(16'h0011, "R7"); ex_wr(16'h0004, "R7"); ex_wr(16'h0001, "R7");
    ex_cmd(16'h0039, "R8"); ex_wr(16'h0000, "R8"); ex_rd(1, "R8");
    if (differs) begin
      ex_cmd(16'h0039, "R9"); ex_wr(16'h0001, "R9"); ex_wr(VCOM_CFG, "R9");
    end
    ex_fast = 1;
    ex_cmd(16'h0034, "R11"); ex_wr(16'h0000, "R11"); ex_wr(16'h0000, "R11");
    ex_wr(16'd1872, "R11"); ex_wr(16'd1404, "R11"); ex_wr(16'h0000, "R11");
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_boot(logic [15:0] vcom_ret, bit busy, int lat_v, string name);
    int waited, n0, bad_w, bad_f, bad_fast;
    vcom_model = vcom_ret; busy_mode = busy; lat_cfg = lat_v;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(panel_rst_n && cs_n && !xfer_valid && !spi_fast && !ready, "R1",
        {name, " reset outputs"},
        {panel_rst_n, cs_n, xfer_valid, spi_fast, ready}, 5'b11000);
    rst = 0;
    @(negedge clk);
    chk(cs_n && !xfer_valid && !ready, "R1", {name, " first cycle"},
        {cs_n, xfer_valid, ready}, 3'b100);
    waited = 0;
    while (!ready && waited < 20000) begin @(negedge clk); waited++; end
    chk(ready, "R12", {name, " ready reached"}, ready, 1);
    // R2: reset pulse length and chip select idle
    chk(lowticks == RST_MS, "R2", {name, " reset ticks"}, lowticks, RST_MS);
    chk(csbad == 0 && prstbad == 0, "R2", {name, " cs/xfer during reset"},
        csbad + prstbad, 0);
    chk(rdybad == 0, "R4", {name, " request without host ready"}, rdybad, 0);
    build_expected(vcom_ret != VCOM_CFG);
    chk(log_n == ex_n, "R3", {name, " transfer count"}, log_n, ex_n);
    bad_w = 0; bad_f = 0; bad_fast = 0;
    for (int i = 0; i < ex_n && i < log_n; i++) begin
      if (log_w[i] !== ex_w[i]) begin
        bad_w++;
        chk(0, ex_tag[i], $sformatf("%s word %0d", name, i), log_w[i], ex_w[i]);
      end
      if (log_f[i] != ex_f[i]) bad_f++;
      if (log_fast[i] != ex_fs[i]) bad_fast++;
    end
    chk(bad_w == 0, "R3", {name, " word stream"}, bad_w, 0);
    chk(bad_f == 0, "R3", {name, " frame grouping"}, bad_f, 0);
    chk(bad_fast == 0, "R10", {name, " clock speed per transfer"}, bad_fast, 0);
    chk(img_addr == {pat(3), pat(2)}, "R6", {name, " image address"},
        img_addr, {pat(3), pat(2)});
    for (int k = 0; k < NW; k++) begin
      info_addr = 5'(k);
      @(negedge clk);
      chk(info_data == pat(k), "R5", $sformatf("%s info word %0d", name, k),
          info_data, pat(k));
    end
    // R12: quiet after completion
    n0 = log_n;
    repeat (30) @(negedge clk);
    chk(ready && log_n == n0 && spi_fast, "R12", {name, " no traffic after ready"},
        log_n, n0);
  endtask

  task automatic scen_vcom_match();
    run_boot(16'd1500, 0, 2, "match");   // R9 skipped
  endtask
  task automatic scen_vcom_differ();
    run_boot(16'd1234, 0, 1, "differ");  // R9 written
  endtask
  task automatic scen_busy_host();
    run_boot(16'd1501, 1, 4, "busy");    // R4 stalls
  endtask

  initial begin
    scen_vcom_match();
    scen_vcom_differ();
    scen_busy_host();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule